// File: doc/BRIEF.md
# Keccak Round Constant Generator

This block supplies the iota round constant for each round of the Keccak-f permutation. It does not read the constants from a table. It steps an 8-bit feedback shift register and collects one constant bit per step. Each round consumes seven steps, and each collected bit lands at one of the seven sparse positions of the lane. The register is never reloaded between rounds, so the constants of successive rounds come out of one continuous sequence.

A round controller pulses `start_i` at the beginning of a permutation. It waits for `valid_o`, uses `const_o` for the round shown on `round_o`, and then pulses `next_i` to move on. The lane width is a parameter (1 to 64 bits, a power of two). It sets both the width of the constant and the number of rounds. Applying the constant to the state and sequencing the rounds are left to the surrounding logic.

Top module: `keccak_rc_gen`

## Requirements
- R1: After a synchronous reset (`rst_i` high at a clock edge), `valid_o` is 0, `round_o` is 0 and `const_o` is all zeros.
- R2: `start_i` is accepted in any state. It reloads the feedback register with the value 0x01, sets `round_o` to 0 and drops `valid_o`. `valid_o` then rises exactly 7 clock edges after the edge that sampled `start_i`.
- R3: For round r, bit position 2^j-1 of the full 64-bit constant equals rc(7r+j), for j = 0 to 6. Every other position is 0. rc(t) is bit 0 of the 8-bit register after t mod 255 steps from 0x01. One step shifts the register left by one with 0 entering bit 0, and when the old bit 7 was 1 it XORs 0x71 into the result (bits 0, 4, 5, 6).
- R4: The constants are 0x0000000000000001 for round 0, 0x0000000000008082 for round 1, 0x800000000000808A for round 2 and 0x8000000080008008 for round 23.
- R5: With lane width W below 64, `const_o` is W bits wide and carries the low W bits of the 64-bit constant. The last round index is 12+2*log2(W)-1.
- R6: `next_i` sampled while `valid_o` is 1 and the round is not the last advances `round_o` by one and drops `valid_o`. The new constant is valid exactly 7 edges later and continues the register sequence without a reload.
- R7: `next_i` sampled while `valid_o` is 0 has no effect: neither the round index nor the constant that follows changes.
- R8: `next_i` at the last round is ignored: `valid_o` stays 1 and `round_o` and `const_o` hold.
- R9: `const_o` is all zeros while `valid_o` is 0. While `valid_o` is 1 and no request arrives, `const_o` holds its value.
- R10: When `start_i` and `next_i` are sampled at the same edge, `start_i` wins and round 0 follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Restart from round 0 with a fresh register |
| next_i | input | 1 | Request the constant of the following round |
| valid_o | output | 1 | Constant for `round_o` is complete |
| round_o | output | $clog2(12+2*log2(LaneW)) | Current round index |
| const_o | output | LaneW | Round constant, low LaneW bits |

## Verification
The bench walks all 24 rounds of a 64-bit instance and all 18 rounds of an 8-bit instance side by side. It compares each constant with a value computed from the rc recurrence, and with the four literal values. This separates a wrong tap set or step count from a wrong bit placement or truncation. It also sends requests in awkward places: `next_i` while idle or mid-collection, at the last round, at the same edge as `start_i`, and `start_i` mid-collection. These cases show whether the round counter, the register continuity and the request priority are separate and correct.

// File: rtl/rcgen_pkg.sv
package rcgen_pkg;

    localparam int LFSR_W     = 8;
    localparam int BITS_PER_RND = 7;
    localparam int FULL_W     = 64;
    localparam int CNT_W      = $clog2(BITS_PER_RND);

    typedef logic [LFSR_W-1:0]       lfsr_t;
    typedef logic [BITS_PER_RND-1:0] rcbits_t;

    localparam lfsr_t LFSR_SEED = 8'h01;
    localparam lfsr_t LFSR_TAPS = 8'h71;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_COLLECT = 2'd1,
        PH_HOLD    = 2'd2
    } phase_e;

    // one feedback step: shift up, fold the outgoing bit into the taps
    function automatic lfsr_t lfsr_step(lfsr_t cur);
        lfsr_t nxt;
        nxt = {cur[LFSR_W-2:0], 1'b0};
        if (cur[LFSR_W-1]) nxt = nxt ^ LFSR_TAPS;
        return nxt;
    endfunction

    // index j such that position k == 2^j-1, or -1 if k is not sparse
    function automatic int sparse_index(int k);
        for (int j = 0; j < BITS_PER_RND; j++) begin
            if (k == (1 << j) - 1) return j;
        end
        return -1;
    endfunction

endpackage

// File: rtl/rcg_lfsr.sv
module rcg_lfsr
    import rcgen_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  load_i,
    input  logic  advance_i,
    output logic  bit_o
);
    lfsr_t state_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || load_i) begin
            state_q <= LFSR_SEED;
        end else if (advance_i) begin
            state_q <= lfsr_step(state_q);
        end
    end

    assign bit_o = state_q[0];

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q != '0);
endmodule

// File: rtl/rcg_sequencer.sv
module rcg_sequencer
    import rcgen_pkg::*;
#(
    parameter int NUM_RNDS = 24,
    parameter int RND_W    = $clog2(NUM_RNDS)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             next_i,
    input  logic             lfsr_bit_i,
    output logic             load_o,
    output logic             advance_o,
    output logic             valid_o,
    output logic [RND_W-1:0] round_o,
    output rcbits_t          bits_o
);
    localparam logic [RND_W-1:0] LAST_RND  = RND_W'(NUM_RNDS - 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(BITS_PER_RND - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] step_q;
    logic [RND_W-1:0] round_q;
    rcbits_t          bits_q;
    logic             take_next;

    assign take_next = next_i && (phase_q == PH_HOLD) && (round_q != LAST_RND);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            round_q <= '0;
            bits_q  <= '0;
        end else if (start_i) begin
            phase_q <= PH_COLLECT;
            step_q  <= '0;
            round_q <= '0;
            bits_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_COLLECT: begin
                    bits_q[step_q] <= lfsr_bit_i;
                    if (step_q == LAST_STEP) begin
                        step_q  <= '0;
                        phase_q <= PH_HOLD;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (take_next) begin
                        round_q <= round_q + 1'b1;
                        bits_q  <= '0;
                        phase_q <= PH_COLLECT;
                    end
                end
                default: ;
            endcase
        end
    end

    assign load_o    = start_i;
    assign advance_o = (phase_q == PH_COLLECT) && !start_i;
    assign valid_o   = (phase_q == PH_HOLD);
    assign round_o   = round_q;
    assign bits_o    = bits_q;

    // R2
    start_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (phase_q == PH_COLLECT) && (round_q == '0));

    // R7
    next_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q != PH_HOLD) && !start_i |=> $stable(round_q));

    // R8
    last_round_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_HOLD) && (round_q == LAST_RND) && !start_i
        |=> (phase_q == PH_HOLD) && $stable(round_q));

    // R6
    round_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        round_q <= LAST_RND);
endmodule

// File: rtl/rcg_spread.sv
module rcg_spread
    import rcgen_pkg::*;
#(
    parameter int LANE_W = 64
) (
    input  logic              valid_i,
    input  rcbits_t           bits_i,
    output logic [LANE_W-1:0] const_o
);
    logic [FULL_W-1:0] full;

    for (genvar k = 0; k < FULL_W; k++) begin : g_pos
        localparam int J = sparse_index(k);
        if (J >= 0) begin : g_sparse
            assign full[k] = bits_i[J];
        end else begin : g_zero
            assign full[k] = 1'b0;
        end
    end

    assign const_o = valid_i ? full[LANE_W-1:0] : '0;
endmodule

// File: rtl/keccak_rc_gen.sv
module keccak_rc_gen
    import rcgen_pkg::*;
#(
    parameter int LANE_W = 64,
    localparam int LOG_W    = $clog2(LANE_W),
    localparam int NUM_RNDS = 12 + 2 * LOG_W,
    localparam int RND_W    = $clog2(NUM_RNDS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              next_i,
    output logic              valid_o,
    output logic [RND_W-1:0]  round_o,
    output logic [LANE_W-1:0] const_o
);
    logic    load, advance, lfsr_bit;
    rcbits_t bits;

    rcg_lfsr u_lfsr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (load),
        .advance_i (advance),
        .bit_o     (lfsr_bit)
    );

    rcg_sequencer #(
        .NUM_RNDS (NUM_RNDS),
        .RND_W    (RND_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (start_i),
        .next_i     (next_i),
        .lfsr_bit_i (lfsr_bit),
        .load_o     (load),
        .advance_o  (advance),
        .valid_o    (valid_o),
        .round_o    (round_o),
        .bits_o     (bits)
    );

    rcg_spread #(
        .LANE_W (LANE_W)
    ) u_spread (
        .valid_i (valid_o),
        .bits_i  (bits),
        .const_o (const_o)
    );

    // R9
    const_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> (const_o == '0));

    // R9
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o && !start_i && !next_i |=> valid_o && $stable(const_o));
endmodule

// File: tb/sim_keccak_rc_gen.sv
module sim_keccak_rc_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic nxt = 1'b0;

    logic        v0, v1;
    logic [4:0]  r0, r1;
    logic [63:0] c0;
    logic [7:0]  c1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    keccak_rc_gen #(.LANE_W(64)) u0 (
        .clk_i(clk), .rst_i(rst), .start_i(start), .next_i(nxt),
        .valid_o(v0), .round_o(r0), .const_o(c0));

    keccak_rc_gen #(.LANE_W(8)) u1 (
        .clk_i(clk), .rst_i(rst), .start_i(start), .next_i(nxt),
        .valid_o(v1), .round_o(r1), .const_o(c1));

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit rc_bit(input int t);
        logic [7:0] s = 8'h01;
        for (int i = 0; i < t % 255; i++) begin
            logic top = s[7];
            s = {s[6:0], 1'b0};
            if (top) s = s ^ 8'h71;
        end
        return s[0];
    endfunction

    function automatic logic [63:0] exp_const(input int r);
        logic [63:0] c = '0;
        for (int j = 0; j < 7; j++) c[(1 << j) - 1] = rc_bit(7 * r + j);
        return c;
    endfunction

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_next();
        nxt = 1'b1;
        @(negedge clk);
        nxt = 1'b0;
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        while (!v0 && n < 50) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(v0 == 1'b0, "R1 valid", 64'(v0), 64'd0);
        chk(c0 == '0, "R1 const", c0, 64'd0);
        chk(r0 == '0, "R1 round", 64'(r0), 64'd0);

        // R7 next while idle
        pulse_next();
        repeat (3) @(negedge clk);
        chk(v0 == 1'b0 && r0 == '0, "R7 idle next", {r0, v0}, 64'd0);

        // R2 start latency
        pulse_start();
        chk(c0 == '0, "R9 zero while collecting", c0, 64'd0);
        wait_valid(n);
        chk(n == 7, "R2 latency", 64'(n), 64'd7);

        for (int r = 0; r < 24; r++) begin
            chk(r0 == 5'(r), "R6 round index", 64'(r0), 64'(r));
            chk(c0 == exp_const(r), "R3 constant", c0, exp_const(r));
            if (r < 18) begin
                chk(r1 == 5'(r) && v1, "R5 narrow round", 64'(r1), 64'(r));
                chk(c1 == exp_const(r)[7:0], "R5 narrow const", 64'(c1),
                    64'(exp_const(r)[7:0]));
            end
            if (r == 0) chk(c0 == 64'h1, "R4 round0", c0, 64'h1);
            if (r == 1) chk(c0 == 64'h8082, "R4 round1", c0, 64'h8082);
            if (r == 2) chk(c0 == 64'h800000000000808A, "R4 round2", c0,
                            64'h800000000000808A);
            if (r == 23) chk(c0 == 64'h8000000080008008, "R4 round23", c0,
                             64'h8000000080008008);
            if (r == 10) begin
                held = c0;
                repeat (5) @(negedge clk);
                chk(v0 && c0 == held, "R9 hold stable", c0, held);
            end
            if (r < 23) begin
                pulse_next();
                chk(v0 == 1'b0 && c0 == '0, "R9 zero after next", c0, 64'd0);
                if (r == 4) begin
                    @(negedge clk);
                    pulse_next();   // R7 next during collection
                end
                wait_valid(n);
                if (r != 4) chk(n == 7, "R6 latency", 64'(n), 64'd7);
            end
        end

        // R8 last round on both instances
        held = c0;
        pulse_next();
        repeat (10) @(negedge clk);
        chk(v0 && r0 == 5'd23 && c0 == held, "R8 last round wide", c0, held);
        chk(v1 && r1 == 5'd17 && c1 == exp_const(17)[7:0], "R8 last round narrow",
            64'(c1), 64'(exp_const(17)[7:0]));

        // R10 start and next together
        start = 1'b1;
        nxt = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nxt = 1'b0;
        wait_valid(n);
        chk(n == 7, "R10 latency", 64'(n), 64'd7);
        chk(r0 == '0 && c0 == 64'h1, "R10 start wins", c0, 64'h1);

        // R2 start during collection
        pulse_next();
        repeat (3) @(negedge clk);
        pulse_start();
        wait_valid(n);
        chk(n == 7, "R2 restart latency", 64'(n), 64'd7);
        chk(r0 == '0 && c0 == 64'h1, "R2 restart const", c0, 64'h1);
        pulse_next();
        wait_valid(n);
        chk(r0 == 5'd1 && c0 == 64'h8082, "R2 reloaded sequence", c0, 64'h8082);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule